// File: doc/BRIEF.md
# Header/Trailer Event Builder

The block assembles events from several input channels, one event at a time. Each channel holds its words in a buffer whose head word is presented to the builder. A channel's share of an event opens with a header word and closes with a trailer word. The builder takes words only from channels that have not yet delivered their trailer for the event now being built. Each word it takes is removed from that channel's buffer and written to an external output FIFO in the same cycle. Words of later events wait in their buffers until the current event is closed.

The event is closed once every enabled channel has delivered its trailer. The builder then pushes one summary entry into an internal summary FIFO. The entry holds the event number and the number of words written for that event. A ready flag tells software that an entry is waiting. Two control bits can switch on optional checks on each header: one for the event number and one for the bunch-crossing number. A failed check raises a sticky flag, and the word is still forwarded.

Top module: `eb_event_builder`

## Requirements
- R1: After reset `evt_ready` and `id_mismatch` are 0, and nothing is popped while no channel presents a word.
- R2: At most one channel is popped per cycle. The pick is round-robin: the search starts at the channel after the last one served, and after reset channel 0 comes first. A channel can be picked only while its `ch_valid` is high, its enable bit is set and it has not yet given its trailer for the current event.
- R3: In the cycle a channel is popped, `out_wr` is 1 and `out_word` equals that channel's head word. `out_wr` is 0 in every other cycle.
- R4: A word whose bits [31:28] equal 0xC is a trailer. After a channel's trailer, the channel's further words stay in its buffer until the current event is closed.
- R5: A channel whose `chan_en` bit is 0 is never popped, and the builder does not wait for its trailer.
- R6: While `out_full` is 1, no channel is popped and `out_wr` stays 0.
- R7: When `chan_en` is nonzero and every enabled channel has given its trailer, one summary entry is pushed. The entry has the event number in bits [27:16] and the word count in bits [15:0]. The event number starts at 0 after reset and increases by 1 for each closed event. The word count includes the header and trailer words.
- R8: `evt_ready` is 1 exactly while the summary FIFO holds an entry. `sum_word` shows the oldest entry, and `sum_rd` removes it when `evt_ready` is 1.
- R9: A header is a word with bits [31:28] equal to 0xA. When `chk_evid_en` is 1, a header whose bits [23:12] differ from the current event number sets `id_mismatch`. The flag stays set until reset, and the word is still forwarded.
- R10: When `chk_bcid_en` is 1, a header whose bits [11:0] differ from those of the first header taken in the same event sets `id_mismatch`.
- R11: While the summary FIFO is full, a finished event is not closed, and no channel that has given its trailer is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_en | input | N_CH | Channel enable bits |
| chk_evid_en | input | 1 | Enable the event-number check on headers |
| chk_bcid_en | input | 1 | Enable the bunch-crossing check on headers |
| ch_valid | input | N_CH | Channel buffer holds a word |
| ch_data | input | N_CH*WORD_W | Head word of each channel buffer, channel i at bits [i*WORD_W +: WORD_W] |
| ch_pop | output | N_CH | Remove the head word of the channel |
| out_full | input | 1 | Output FIFO cannot take a word |
| out_wr | output | 1 | Write strobe to the output FIFO |
| out_word | output | WORD_W | Word written to the output FIFO |
| sum_rd | input | 1 | Remove the oldest summary entry |
| sum_word | output | ID_W+WC_W | Oldest summary entry: event number and word count |
| evt_ready | output | 1 | A summary entry is waiting |
| id_mismatch | output | 1 | Sticky header check failure |

## Verification
Some properties are checked on every cycle at the ports: at most one pop per cycle, pops only on enabled channels that present a word, a write strobe exactly when a word is popped, no writes while the output FIFO is full, a sticky mismatch flag, and a ready flag that holds until a read. Other behaviour only shows up in the bench's scenarios, which follow a behavioural model cycle by cycle. This covers the round-robin order, words held back after a trailer, the summary contents and count, a full summary FIFO stalling the close of an event, and which header values raise the mismatch flag.

// File: rtl/eb_pkg.sv
// Package eb_pkg: word-type codes shared by the event builder modules.
// Assumes the type code sits in the top four bits of every channel word.
package eb_pkg;
    localparam int TYPE_W = 4;
    localparam logic [TYPE_W-1:0] TYPE_HDR = 4'hA;
    localparam logic [TYPE_W-1:0] TYPE_TRL = 4'hC;
endpackage

// File: rtl/eb_rr_arb.sv
// eb_rr_arb: round-robin picker over N requesters.
// The search starts one place after the last served requester.
// Assumes adv is asserted only in a cycle where gnt_vld is high.
module eb_rr_arb #(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    input  logic             adv,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] gnt_idx,
    output logic             gnt_vld
);
    logic [IDX_W-1:0] last_q;

    // Find the first requester after the last one served
    always_comb begin
        int j;
        gnt_vld = 1'b0;
        gnt_idx = '0;
        for (int k = 1; k <= N; k++) begin
            j = (int'(last_q) + k) % N;
            if (!gnt_vld && req[j]) begin
                gnt_vld = 1'b1;
                gnt_idx = IDX_W'(j);
            end
        end
        gnt = gnt_vld ? (N'(1) << gnt_idx) : '0;
    end

    // Remember the last served requester
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= IDX_W'(N - 1);
        else if (adv)
            last_q <= gnt_idx;
    end
endmodule

// File: rtl/eb_sync_fifo.sv
// eb_sync_fifo: small single-clock FIFO whose head word is shown on dout.
// Assumes the caller never writes when full and never reads when empty.
module eb_sync_fifo #(
    parameter int W     = 28,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] din,
    input  logic         rd,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [AW:0]   cnt_q;

    assign dout  = mem[rp_q];
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == (AW+1)'(DEPTH));

    // Store a written word
    always_ff @(posedge clk) begin
        if (wr)
            mem[wp_q] <= din;
    end

    // Move the pointers and the fill count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (wr)
                wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
            if (rd)
                rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
            if (wr && !rd)
                cnt_q <= cnt_q + (AW+1)'(1);
            else if (rd && !wr)
                cnt_q <= cnt_q - (AW+1)'(1);
        end
    end
endmodule

// File: rtl/eb_id_check.sv
// eb_id_check: compares the ID fields of a header against the event state.
// Pure combinational logic. The bunch-crossing reference counts only once
// a first header has been taken in the event.
module eb_id_check #(
    parameter int ID_W = 12
) (
    input  logic            is_hdr,
    input  logic            chk_evid_en,
    input  logic            chk_bcid_en,
    input  logic [ID_W-1:0] hdr_evid,
    input  logic [ID_W-1:0] hdr_bcid,
    input  logic [ID_W-1:0] cur_evid,
    input  logic [ID_W-1:0] bcid_ref,
    input  logic            bcid_ref_vld,
    output logic            bad
);
    logic evid_bad, bcid_bad;

    // Flag a header that fails any enabled check
    always_comb begin
        evid_bad = chk_evid_en && (hdr_evid != cur_evid);
        bcid_bad = chk_bcid_en && bcid_ref_vld && (hdr_bcid != bcid_ref);
        bad      = is_hdr && (evid_bad || bcid_bad);
    end
endmodule

// File: rtl/eb_event_builder.sv
// eb_event_builder: pulls header/trailer delimited segments from N channel
// buffers, forwards the words of the current event, and publishes an
// event-number/word-count entry once every enabled channel has closed.
// Assumes ch_data shows the head word of each buffer and that the buffer
// drops that word when ch_pop is high at a clock edge.
module eb_event_builder
    import eb_pkg::*;
#(
    parameter int N_CH      = 4,
    parameter int WORD_W    = 32,
    parameter int ID_W      = 12,
    parameter int WC_W      = 16,
    parameter int SUM_DEPTH = 4,
    localparam int SUM_W    = ID_W + WC_W,
    localparam int IDX_W    = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_CH-1:0]        chan_en,
    input  logic                   chk_evid_en,
    input  logic                   chk_bcid_en,
    input  logic [N_CH-1:0]        ch_valid,
    input  logic [N_CH*WORD_W-1:0] ch_data,
    output logic [N_CH-1:0]        ch_pop,
    input  logic                   out_full,
    output logic                   out_wr,
    output logic [WORD_W-1:0]      out_word,
    input  logic                   sum_rd,
    output logic [SUM_W-1:0]       sum_word,
    output logic                   evt_ready,
    output logic                   id_mismatch
);
    logic [WORD_W-1:0] ch_word [N_CH];
    logic [N_CH-1:0]   done_q, req, gnt;
    logic [IDX_W-1:0]  gnt_idx;
    logic              gnt_vld;
    logic [WORD_W-1:0] sel_word;
    logic              is_hdr, is_trl, hdr_bad;
    logic              all_done, close_evt, sum_empty, sum_full;
    logic [ID_W-1:0]   evid_q, bcid_ref_q;
    logic              bcid_ref_vld_q, mism_q;
    logic [WC_W-1:0]   wc_q;

    // Unpack the flat channel bus into one word per channel
    for (genvar g = 0; g < N_CH; g++) begin : g_unpack
        assign ch_word[g] = ch_data[g*WORD_W +: WORD_W];
    end

    // A channel may be served if it holds a word, is enabled, is still open
    assign req = ch_valid & chan_en & ~done_q & {N_CH{~out_full}};

    eb_rr_arb #(.N(N_CH)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .adv     (gnt_vld),
        .gnt     (gnt),
        .gnt_idx (gnt_idx),
        .gnt_vld (gnt_vld)
    );

    // Decode the selected word and decide whether the event can close
    always_comb begin
        sel_word  = ch_word[gnt_idx];
        is_hdr    = (sel_word[WORD_W-1 -: TYPE_W] == TYPE_HDR);
        is_trl    = (sel_word[WORD_W-1 -: TYPE_W] == TYPE_TRL);
        all_done  = (chan_en != '0) && ((done_q | ~chan_en) == '1);
        close_evt = all_done && !sum_full;
    end

    eb_id_check #(.ID_W(ID_W)) u_chk_id (
        .is_hdr       (is_hdr && gnt_vld),
        .chk_evid_en  (chk_evid_en),
        .chk_bcid_en  (chk_bcid_en),
        .hdr_evid     (sel_word[2*ID_W-1:ID_W]),
        .hdr_bcid     (sel_word[ID_W-1:0]),
        .cur_evid     (evid_q),
        .bcid_ref     (bcid_ref_q),
        .bcid_ref_vld (bcid_ref_vld_q),
        .bad          (hdr_bad)
    );

    // Track per-channel closure, event number, word count and reference
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q         <= '0;
            evid_q         <= '0;
            wc_q           <= '0;
            bcid_ref_q     <= '0;
            bcid_ref_vld_q <= 1'b0;
            mism_q         <= 1'b0;
        end else begin
            if (close_evt) begin
                done_q         <= '0;
                evid_q         <= evid_q + ID_W'(1);
                wc_q           <= '0;
                bcid_ref_vld_q <= 1'b0;
            end else if (gnt_vld) begin
                wc_q <= wc_q + WC_W'(1);
                if (is_trl)
                    done_q <= done_q | gnt;
                if (is_hdr && !bcid_ref_vld_q) begin
                    bcid_ref_q     <= sel_word[ID_W-1:0];
                    bcid_ref_vld_q <= 1'b1;
                end
            end
            if (hdr_bad)
                mism_q <= 1'b1;
        end
    end

    eb_sync_fifo #(.W(SUM_W), .DEPTH(SUM_DEPTH)) u_sum_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (close_evt),
        .din   ({evid_q, wc_q}),
        .rd    (sum_rd && !sum_empty),
        .dout  (sum_word),
        .empty (sum_empty),
        .full  (sum_full)
    );

    assign ch_pop      = gnt;
    assign out_wr      = gnt_vld;
    assign out_word    = sel_word;
    assign evt_ready   = !sum_empty;
    assign id_mismatch = mism_q;
endmodule

// File: rtl/eb_event_builder_chk.sv
// eb_event_builder_chk: port-level properties of the event builder,
// attached to every instance of the top by the bind below.
module eb_event_builder_chk #(
    parameter int N_CH = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_CH-1:0] chan_en,
    input logic [N_CH-1:0] ch_valid,
    input logic [N_CH-1:0] ch_pop,
    input logic            out_full,
    input logic            out_wr,
    input logic            id_mismatch,
    input logic            evt_ready,
    input logic            sum_rd
);
    // R2: never more than one channel popped in a cycle
    a_r2_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_pop));

    // R5: disabled channels are never popped
    a_r5_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_pop & ~chan_en) == '0);

    // R3: a pop needs a word in the buffer
    a_r3_pop_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_pop & ~ch_valid) == '0);

    // R3: write strobe exactly with a pop
    a_r3_write_with_pop: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr == (ch_pop != '0));

    // R6: no write into a full output FIFO
    a_r6_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        out_full |-> !out_wr);

    // R9: mismatch flag is sticky
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        id_mismatch |=> id_mismatch);

    // R8: a waiting entry stays until read
    a_r8_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_ready && !sum_rd) |=> evt_ready);
endmodule

bind eb_event_builder eb_event_builder_chk #(.N_CH(N_CH)) u_eb_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .chan_en     (chan_en),
    .ch_valid    (ch_valid),
    .ch_pop      (ch_pop),
    .out_full    (out_full),
    .out_wr      (out_wr),
    .id_mismatch (id_mismatch),
    .evt_ready   (evt_ready),
    .sum_rd      (sum_rd)
);

// File: tb/eb_event_builder_tb_top.sv
// Bench for eb_event_builder: channel buffers are bench queues, a
// behavioural model predicts every output and is compared each clock.
module eb_event_builder_tb_top;
    localparam int NC = 4;
    localparam int WW = 32;
    localparam int SD = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NC-1:0]   chan_en = '0;
    logic            chk_evid_en = 1'b0, chk_bcid_en = 1'b0;
    logic [NC-1:0]   ch_valid = '0;
    logic [NC*WW-1:0] ch_data = '0;
    logic [NC-1:0]   ch_pop;
    logic            out_full = 1'b0;
    logic            out_wr;
    logic [WW-1:0]   out_word;
    logic            sum_rd = 1'b0;
    logic [27:0]     sum_word;
    logic            evt_ready;
    logic            id_mismatch;

    eb_event_builder #(.N_CH(NC), .WORD_W(WW), .ID_W(12), .WC_W(16), .SUM_DEPTH(SD)) dut_i (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .chk_evid_en(chk_evid_en),
        .chk_bcid_en(chk_bcid_en), .ch_valid(ch_valid), .ch_data(ch_data),
        .ch_pop(ch_pop), .out_full(out_full), .out_wr(out_wr), .out_word(out_word),
        .sum_rd(sum_rd), .sum_word(sum_word), .evt_ready(evt_ready),
        .id_mismatch(id_mismatch)
    );

    always #5 clk = ~clk;

    int n_checks = 0, n_errors = 0, cyc = 0;
    bit finished = 0;

    // Bench-owned channel buffers and model state
    logic [31:0] bq [NC][$];
    logic [27:0] sumq [$];
    bit [NC-1:0] m_done;
    int          m_last;
    logic [11:0] m_evid, m_bref;
    logic [15:0] m_wc;
    bit          m_bvld, m_mism;
    bit          cur_full = 0, cur_rd = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic model_clear();
        m_done = '0; m_last = NC - 1; m_evid = '0; m_bref = '0; m_wc = '0;
        m_bvld = 0; m_mism = 0; sumq.delete();
    endtask

    task automatic push_evt(input int ch, input logic [11:0] ev, input logic [11:0] bc, input int nd);
        bq[ch].push_back({4'hA, 4'h0, ev, bc});
        for (int k = 0; k < nd; k++) bq[ch].push_back({4'h3, 28'(ch * 256 + k)});
        bq[ch].push_back({4'hC, 16'h0, ev});
    endtask

    // One clock: drive, compare against the model, advance the model
    task automatic step();
        int g;
        bit all_done, rdy, sfull;
        logic [31:0] w;
        @(negedge clk);
        for (int i = 0; i < NC; i++) begin
            ch_valid[i] = (bq[i].size() > 0);
            ch_data[i*WW +: WW] = (bq[i].size() > 0) ? bq[i][0] : '0;
        end
        out_full = cur_full;
        sum_rd = cur_rd;
        #1;
        all_done = (chan_en != 0) && ((m_done | ~chan_en) == '1);
        rdy = (sumq.size() > 0);
        sfull = (sumq.size() >= SD);
        g = -1;
        if (!cur_full)
            for (int k = 1; k <= NC; k++) begin
                int j;
                j = (m_last + k) % NC;
                if (g < 0 && chan_en[j] && !m_done[j] && bq[j].size() > 0) g = j;
            end
        chk(ch_pop == ((g >= 0) ? NC'(1) << g : '0), "R2/R4/R5/R6 ch_pop", 64'(ch_pop),
            (g >= 0) ? 64'(1) << g : 64'(0));
        chk(out_wr == (g >= 0), "R3 out_wr", 64'(out_wr), 64'(g >= 0));
        if (g >= 0) chk(out_word == bq[g][0], "R3 out_word", 64'(out_word), 64'(bq[g][0]));
        chk(evt_ready == rdy, "R8 evt_ready", 64'(evt_ready), 64'(rdy));
        if (rdy) chk(sum_word == sumq[0], "R7 sum_word", 64'(sum_word), 64'(sumq[0]));
        chk(id_mismatch == m_mism, "R9/R10 id_mismatch", 64'(id_mismatch), 64'(m_mism));
        if (cur_rd && rdy) void'(sumq.pop_front());
        if (all_done && !sfull) begin
            sumq.push_back({m_evid, m_wc});
            m_done = '0; m_evid = m_evid + 12'd1; m_wc = '0; m_bvld = 0;
        end else if (g >= 0) begin
            w = bq[g].pop_front();
            m_wc = m_wc + 16'd1;
            m_last = g;
            if (w[31:28] == 4'hC) m_done[g] = 1;
            if (w[31:28] == 4'hA) begin
                if (chk_evid_en && w[23:12] != m_evid) m_mism = 1;
                if (chk_bcid_en && m_bvld && w[11:0] != m_bref) m_mism = 1;
                if (!m_bvld) begin m_bref = w[11:0]; m_bvld = 1; end
            end
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_reset();
        for (int i = 0; i < NC; i++) bq[i].delete();
        model_clear();
        @(negedge clk);
        rst_n = 0; ch_valid = '0; ch_data = '0; sum_rd = 0; out_full = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk(evt_ready == 0, "R1 evt_ready", 64'(evt_ready), 0);
        chk(id_mismatch == 0, "R1 id_mismatch", 64'(id_mismatch), 0);
        chk(ch_pop == 0, "R1 ch_pop", 64'(ch_pop), 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        do_reset();
        // Scenario 1: all channels, three events, summary FIFO fills (R7, R11)
        chan_en = 4'b1111;
        for (int e = 0; e < 3; e++)
            for (int c = 0; c < NC; c++) push_evt(c, 12'(e), 12'h055, c);
        run(80);
        chk(evt_ready == 1, "R11 ready while stalled", 64'(evt_ready), 1);
        push_evt(0, 12'd3, 12'h055, 0);
        run(10);
        chk(bq[0].size() == 2, "R11 ch0 held while full", 64'(bq[0].size()), 2);
        cur_rd = 1;
        run(12);
        chk(bq[0].size() == 0, "R11 ch0 taken after drain", 64'(bq[0].size()), 0);
        // Scenario 2: two channels enabled, junk on a disabled one (R4, R5)
        chan_en = 4'b0101;
        for (int k = 0; k < 3; k++) bq[1].push_back(32'h0000_0BAD + k);
        push_evt(2, 12'd3, 12'h055, 1);
        push_evt(0, 12'd4, 12'h055, 2);
        push_evt(0, 12'd5, 12'h055, 0);
        run(30);
        chk(bq[0].size() == 2, "R4 next event held on ch0", 64'(bq[0].size()), 2);
        chk(bq[1].size() == 3, "R5 disabled ch1 untouched", 64'(bq[1].size()), 3);
        push_evt(2, 12'd4, 12'h055, 0);
        push_evt(2, 12'd5, 12'h055, 3);
        run(30);
        chk(bq[0].size() == 0, "R4 ch0 released", 64'(bq[0].size()), 0);
        // Scenario 3: output FIFO full (R6)
        push_evt(0, 12'd6, 12'h055, 1);
        push_evt(2, 12'd6, 12'h055, 1);
        cur_full = 1;
        run(10);
        chk(bq[0].size() == 3 && bq[2].size() == 3, "R6 nothing taken while full",
            64'(bq[0].size() + bq[2].size()), 6);
        cur_full = 0;
        run(20);
        // Scenario 4: bunch-crossing check (R10)
        chk_bcid_en = 1;
        push_evt(0, 12'd7, 12'h010, 0);
        push_evt(2, 12'd7, 12'h011, 0);
        run(20);
        chk(id_mismatch == 1, "R10 bcid mismatch flagged", 64'(id_mismatch), 1);
        // Scenario 5: event-number check (R9)
        chk_bcid_en = 0;
        do_reset();
        chk_evid_en = 1;
        chan_en = 4'b0011;
        push_evt(0, 12'd0, 12'h020, 1);
        push_evt(1, 12'd0, 12'h020, 2);
        run(20);
        chk(id_mismatch == 0, "R9 matching header clean", 64'(id_mismatch), 0);
        push_evt(0, 12'd5, 12'h020, 0);
        push_evt(1, 12'd1, 12'h020, 0);
        run(20);
        chk(id_mismatch == 1, "R9 wrong event number flagged", 64'(id_mismatch), 1);
        run(10);
        chk(id_mismatch == 1, "R9 flag sticky", 64'(id_mismatch), 1);
        finish_run();
    end
endmodule